// File: doc/BRIEF.md
# Shared-Bus Arbiter with Interrupt Vector Fetch

This block owns a shared peripheral bus with a single master. It hands the bus to a direct-memory-access requester, and it fetches interrupt vectors for a host CPU. Devices that want an interrupt raise one of several prioritized request lines. The arbiter does not grant these lines on its own. It grants one of them only when the host reads the vector register. The selected device then answers with a selection acknowledge and, while still holding it, presents its vector with an interrupt line and a sync strobe. When the acknowledge drops, the host read completes with that vector.

Another device may steal the grant: it takes the acknowledge and releases it without ever raising the interrupt line. The read then still completes and returns zero. If no acknowledge arrives at all, a timeout ends the read with zero and sets a sticky status flag. The host can read that flag, and reading it clears it. After each bus transaction a guard interval must pass before any new grant, so that requests left over from the old transaction are not arbitrated again.

The host side is a one-cycle read request with a select bit and a one-cycle done pulse carrying 16-bit data. It has no back-pressure. The host keeps at most one read outstanding, and the block ignores any request made while a vector read is outstanding.

Top module: `bus_vec_arbiter`

## Requirements
- R1: When the bus is free and `dma_req` is high, `dma_gnt` is granted on the next edge and no `irq_gnt` bit is driven, even if a vector read and interrupt requests are pending in the same cycle; the vector read stays pending.
- R2: Let E be the clock edge at which `dev_ack` is first sampled low after a transaction that had an acknowledge. No grant is driven after edges E through E+GUARD_CYCLES-1. A pending request is granted at edge E+GUARD_CYCLES.
- R3: Interrupt requests alone never cause an `irq_gnt`. A grant follows only a vector read (`rd_req` high with `rd_sel`=0).
- R4: From the moment an interrupt grant is issued until the guard interval after its acknowledge drops, `dma_gnt` stays low even if `dma_req` is high.
- R5: If the device raises `dev_intr` and `dev_sync` together while `dev_ack` is high, `rd_done` pulses with `rd_data` equal to the `dev_vec` captured then. The pulse follows the edge at which `dev_ack` is sampled low.
- R6: If `dev_ack` is raised and then released without `dev_intr` with `dev_sync`, the read completes at the edge where `dev_ack` is sampled low, with `rd_data`=0.
- R7: If no acknowledge arrives, the interrupt grant is held for TIMEOUT_CYCLES cycles. The read then completes with `rd_data`=0 and the grant drops. A status read (`rd_sel`=1) afterwards returns bit 0 = 1, and the next status read returns 0.
- R8: Of the asserted `irq_req` bits, only the highest-numbered one is granted, and `irq_gnt` is never more than one-hot.
- R9: The edge after `dev_ack` is sampled high, no grant is driven, and no grant is issued while `dev_ack` is high.
- R10: A vector read with no interrupt request pending on an idle bus completes one cycle after its acceptance with `rd_data`=0.
- R11: A read request made while a vector read is outstanding is ignored and produces no `rd_done`.
- R12: After reset `dma_gnt`, `irq_gnt` and `rd_done` are low and the status flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | DMA bus request |
| dma_gnt | output | 1 | DMA bus grant |
| irq_req | input | LEVELS | Interrupt requests, higher index wins |
| irq_gnt | output | LEVELS | Interrupt grant, one-hot or zero |
| dev_ack | input | 1 | Selection acknowledge from the bus owner |
| dev_intr | input | 1 | Device signals an interrupt vector |
| dev_sync | input | 1 | Strobe qualifying the vector |
| dev_vec | input | VEC_W | Vector data from the device |
| rd_req | input | 1 | One-cycle host read request |
| rd_sel | input | 1 | 0 = vector register, 1 = status register |
| rd_done | output | 1 | One-cycle read completion |
| rd_data | output | VEC_W | Read data, valid with rd_done |

## Verification
Every result is due at a fixed edge. A status read completes one edge after acceptance. A vector read on an idle bus grants one edge after acceptance, or completes with zero at that edge when nothing is requesting. A grant drops one edge after the acknowledge is seen. A vector completion comes at the edge where the acknowledge is sampled low. A new grant appears exactly GUARD_CYCLES edges after that edge, and a timeout fires TIMEOUT_CYCLES edges after the grant. The bench drives inputs and samples outputs at the falling edge. It advances one rising edge at a time and checks each output at the exact edge counted above, and it also checks the quiet cycles just before.

// File: rtl/bva_pkg.sv
package bva_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_DGNT,
    ST_DBUSY,
    ST_IGNT,
    ST_IBUSY
  } bva_state_t;

  localparam logic SEL_VECTOR = 1'b0;
  localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/bva_level_pick.sv
module bva_level_pick #(
  parameter int LEVELS = 4,
  localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [LEVELS-1:0] req,
  output logic              any,
  output logic [LW-1:0]     idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (req[i]) idx = i[LW-1:0];
    end
  end

  assign any = |req;
endmodule

// File: rtl/bva_cycle_timer.sv
module bva_cycle_timer #(
  parameter int LIMIT = 19,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(LIMIT - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bus_vec_arbiter.sv
module bus_vec_arbiter
  import bva_pkg::*;
#(
  parameter int LEVELS         = 4,
  parameter int VEC_W          = 16,
  parameter int GUARD_CYCLES   = 19,
  parameter int TIMEOUT_CYCLES = 64,
  localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_req,
  output logic              dma_gnt,
  input  logic [LEVELS-1:0] irq_req,
  output logic [LEVELS-1:0] irq_gnt,
  input  logic              dev_ack,
  input  logic              dev_intr,
  input  logic              dev_sync,
  input  logic [VEC_W-1:0]  dev_vec,
  input  logic              rd_req,
  input  logic              rd_sel,
  output logic              rd_done,
  output logic [VEC_W-1:0]  rd_data
);
  bva_state_t       state;
  logic             vpend;
  logic             got_vec;
  logic             to_flag;
  logic [LW-1:0]    lvl;
  logic [VEC_W-1:0] vec_q;

  logic          any_irq;
  logic [LW-1:0] top_idx;
  logic          guard_exp;
  logic          to_exp;
  logic          bus_free;
  logic          guard_start;
  logic          to_start;

  bva_level_pick #(.LEVELS(LEVELS)) u_pick (
    .req (irq_req),
    .any (any_irq),
    .idx (top_idx)
  );

  assign bus_free = !dev_ack &&
                    ((state == ST_IDLE) || (state == ST_GUARD && guard_exp));
  assign guard_start = ((state == ST_DBUSY) || (state == ST_IBUSY)) && !dev_ack;
  assign to_start    = bus_free && !dma_req && vpend && any_irq;

  bva_cycle_timer #(.LIMIT(GUARD_CYCLES)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (guard_start),
    .expired (guard_exp)
  );

  bva_cycle_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timeout (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (to_start),
    .expired (to_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vpend   <= 1'b0;
      got_vec <= 1'b0;
      to_flag <= 1'b0;
      lvl     <= '0;
      vec_q   <= '0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= 1'b0;
      // host side: one outstanding vector read at a time
      if (rd_req && !vpend) begin
        if (rd_sel == SEL_STATUS) begin
          rd_done <= 1'b1;
          rd_data <= {{(VEC_W-1){1'b0}}, to_flag};
          to_flag <= 1'b0;
        end else begin
          vpend <= 1'b1;
        end
      end
      unique case (state)
        ST_IDLE, ST_GUARD: begin
          if (bus_free) begin
            if (dma_req) begin
              state <= ST_DGNT;
            end else if (vpend && any_irq) begin
              state <= ST_IGNT;
              lvl   <= top_idx;
            end else begin
              state <= ST_IDLE;
              if (vpend) begin
                vpend   <= 1'b0;
                rd_done <= 1'b1;
                rd_data <= '0;
              end
            end
          end
        end
        ST_DGNT: begin
          if (dev_ack)       state <= ST_DBUSY;
          else if (!dma_req) state <= ST_IDLE;
        end
        ST_DBUSY: begin
          if (!dev_ack) state <= ST_GUARD;
        end
        ST_IGNT: begin
          if (dev_ack) begin
            state   <= ST_IBUSY;
            got_vec <= 1'b0;
          end else if (to_exp) begin
            state   <= ST_IDLE;
            vpend   <= 1'b0;
            to_flag <= 1'b1;
            rd_done <= 1'b1;
            rd_data <= '0;
          end
        end
        ST_IBUSY: begin
          if (!dev_ack) begin
            state   <= ST_GUARD;
            vpend   <= 1'b0;
            rd_done <= 1'b1;
            rd_data <= got_vec ? vec_q : '0;
          end else if (dev_intr && dev_sync) begin
            vec_q   <= dev_vec;
            got_vec <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dma_gnt = (state == ST_DGNT);

  for (genvar g = 0; g < LEVELS; g++) begin : g_gnt
    assign irq_gnt[g] = (state == ST_IGNT) && (lvl == LW'(g));
  end

  a_r1_dma_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && dma_req) |=> (dma_gnt && irq_gnt == '0));

  a_r2_guard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GUARD && !guard_exp) |=> (!dma_gnt && irq_gnt == '0));

  a_r3_irq_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE || state == ST_GUARD) && !vpend) |=> (irq_gnt == '0));

  a_r4_no_dma_in_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_gnt) |=> !dma_gnt);

  a_r6_steal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IBUSY && !dev_ack && !got_vec) |=> (rd_done && rd_data == '0));

  a_r7_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNT && !dev_ack && to_exp) |=> (rd_done && to_flag));

  a_r8_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_gnt));

  a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (!dma_gnt && irq_gnt == '0));
endmodule

// File: tb/bus_vec_arbiter_bench.sv
`timescale 1ns/1ps
module bus_vec_arbiter_bench;
  localparam int LEVELS = 4;
  localparam int VEC_W  = 16;
  localparam int G      = 19;
  localparam int T      = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dma_req = 1'b0;
  logic              dma_gnt;
  logic [LEVELS-1:0] irq_req = '0;
  logic [LEVELS-1:0] irq_gnt;
  logic              dev_ack = 1'b0;
  logic              dev_intr = 1'b0;
  logic              dev_sync = 1'b0;
  logic [VEC_W-1:0]  dev_vec = '0;
  logic              rd_req = 1'b0;
  logic              rd_sel = 1'b0;
  logic              rd_done;
  logic [VEC_W-1:0]  rd_data;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bus_vec_arbiter #(
    .LEVELS(LEVELS), .VEC_W(VEC_W), .GUARD_CYCLES(G), .TIMEOUT_CYCLES(T)
  ) u_bus_vec_arbiter (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_gnt(dma_gnt),
    .irq_req(irq_req), .irq_gnt(irq_gnt), .dev_ack(dev_ack),
    .dev_intr(dev_intr), .dev_sync(dev_sync), .dev_vec(dev_vec),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_done(rd_done), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_wait();
    repeat (G + 3) step();
  endtask

  task automatic vread();
    rd_req = 1'b1; rd_sel = 1'b0;
    step();
    rd_req = 1'b0;
  endtask

  task automatic sread(input string tag, input logic [VEC_W-1:0] exp);
    rd_req = 1'b1; rd_sel = 1'b1;
    step();
    rd_req = 1'b0; rd_sel = 1'b0;
    chk({tag, " status done"}, 32'(rd_done), 32'd1);
    chk({tag, " status data"}, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R12 dma_gnt after reset", 32'(dma_gnt), 32'd0);
    chk("R12 irq_gnt after reset", 32'(irq_gnt), 32'd0);
    chk("R12 rd_done after reset", 32'(rd_done), 32'd0);
    sread("R12", 16'h0000);
  endtask

  task automatic t_empty_read();
    vread();
    chk("R10 no done at accept", 32'(rd_done), 32'd0);
    step();
    chk("R10 done", 32'(rd_done), 32'd1);
    chk("R10 zero data", 32'(rd_data), 32'd0);
    chk("R10 no grant", 32'(irq_gnt), 32'd0);
    idle_wait();
  endtask

  task automatic t_irq_alone();
    irq_req = 4'b0100;
    for (int i = 0; i < 10; i++) begin
      step();
      chk("R3 request alone not granted", 32'(irq_gnt), 32'd0);
    end
    irq_req = '0;
    step();
  endtask

  task automatic t_vector();
    irq_req = 4'b0101;
    vread();
    chk("R5 no grant at accept", 32'(irq_gnt), 32'd0);
    step();
    chk("R8 highest level only", 32'(irq_gnt), 32'h4);
    dev_ack = 1'b1;
    step();
    chk("R9 grant dropped on ack", 32'(irq_gnt), 32'd0);
    dev_intr = 1'b1; dev_sync = 1'b1; dev_vec = 16'hA5C3;
    step();
    chk("R5 no done while ack high", 32'(rd_done), 32'd0);
    dev_intr = 1'b0; dev_sync = 1'b0; dev_vec = '0; dev_ack = 1'b0; irq_req = '0;
    step();
    chk("R5 done on ack low", 32'(rd_done), 32'd1);
    chk("R5 vector returned", 32'(rd_data), 32'hA5C3);
    idle_wait();
  endtask

  task automatic t_steal();
    irq_req = 4'b0010;
    vread();
    step();
    chk("R8 single level grant", 32'(irq_gnt), 32'h2);
    dev_ack = 1'b1; irq_req = '0;
    step();
    chk("R9 grant dropped on ack", 32'(irq_gnt), 32'd0);
    dev_ack = 1'b0;
    step();
    chk("R6 stolen grant done", 32'(rd_done), 32'd1);
    chk("R6 stolen grant zero", 32'(rd_data), 32'd0);
    step();
    sread("R6 no timeout flag", 16'h0000);
    idle_wait();
  endtask

  task automatic t_timeout();
    irq_req = 4'b1000;
    vread();
    step();
    chk("R7 grant issued", 32'(irq_gnt), 32'h8);
    for (int i = 1; i < T; i++) begin
      if (i == 5) begin
        rd_req = 1'b1; rd_sel = 1'b1;
      end
      step();
      rd_req = 1'b0; rd_sel = 1'b0;
      if (i == 5) chk("R11 read ignored while outstanding", 32'(rd_done), 32'd0);
      else chk("R7 no early done", 32'(rd_done), 32'd0);
    end
    chk("R7 grant held to timeout", 32'(irq_gnt), 32'h8);
    step();
    chk("R7 timeout done", 32'(rd_done), 32'd1);
    chk("R7 timeout zero", 32'(rd_data), 32'd0);
    chk("R7 grant dropped", 32'(irq_gnt), 32'd0);
    irq_req = '0;
    step();
    sread("R7 flag set", 16'h0001);
    sread("R7 flag cleared", 16'h0000);
    idle_wait();
  endtask

  task automatic t_dma_prio();
    dma_req = 1'b1; irq_req = 4'b0001; rd_req = 1'b1; rd_sel = 1'b0;
    step();
    rd_req = 1'b0;
    chk("R1 dma granted", 32'(dma_gnt), 32'd1);
    chk("R1 irq held off", 32'(irq_gnt), 32'd0);
    step();
    chk("R1 irq still held off", 32'(irq_gnt), 32'd0);
    dev_ack = 1'b1;
    step();
    chk("R9 dma grant dropped on ack", 32'(dma_gnt), 32'd0);
    dma_req = 1'b0; dev_ack = 1'b0;
    step();
    for (int i = 1; i < G; i++) begin
      step();
      chk("R2 quiet during guard", 32'(irq_gnt), 32'd0);
    end
    step();
    chk("R2 grant at guard end", 32'(irq_gnt), 32'h1);
    dma_req = 1'b1; dev_ack = 1'b1;
    step();
    chk("R4 no dma during irq", 32'(dma_gnt), 32'd0);
    dev_intr = 1'b1; dev_sync = 1'b1; dev_vec = 16'h0042;
    step();
    chk("R4 no dma during vector", 32'(dma_gnt), 32'd0);
    dev_intr = 1'b0; dev_sync = 1'b0; dev_vec = '0; dev_ack = 1'b0; irq_req = '0;
    step();
    chk("R5 vector after dma", 32'(rd_data), 32'h0042);
    chk("R4 no dma at completion", 32'(dma_gnt), 32'd0);
    for (int i = 1; i < G; i++) begin
      step();
      chk("R4 dma held through guard", 32'(dma_gnt), 32'd0);
    end
    step();
    chk("R2 dma granted after guard", 32'(dma_gnt), 32'd1);
    dev_ack = 1'b1;
    step();
    dma_req = 1'b0; dev_ack = 1'b0;
    step();
    idle_wait();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_empty_read();
    t_irq_alone();
    t_vector();
    t_steal();
    t_timeout();
    t_dma_prio();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule